// File: doc/BRIEF.md
# DMA Channel Teardown Controller

This block is the control slice of one channel in a descriptor-based DMA engine. It holds the channel's configuration word and runs the shutdown sequence that software starts by setting the teardown request bit while the channel is enabled. Data movement, bus mastering and descriptor prefetch live elsewhere. The block only coordinates with the queue manager and descriptor memory through three request/acknowledge handshakes.

A teardown does four things in turn. The block asks the queue manager for a descriptor from the free queue named in a second register. It writes a self-describing teardown record into that descriptor. It pushes the descriptor onto the channel's completion queue. It then drops the enable and teardown bits by hardware. Software sees the channel as enabled until the record has been handed back. Software that later writes zero to the configuration word leaves the channel fully idle. Each instance is fixed as a receive or a transmit channel and carries its own port number.

Top module: `dma_td_ctrl`

## Requirements
- R1: After reset the configuration word and the teardown-queue register both read 0, `busy` is 0 and none of `pop_req`, `rec_wr_req` or `push_req` is asserted.
- R2: The configuration word (`cfg_sel`=0) reads back as written: bit 31 is enable, bit 30 is the teardown request, and bits 11:0 are the completion queue number. Bit 24 (starvation retry) and bit 14 (host descriptor type) are kept only when `IS_RX` is 1 and read 0 on a transmit channel. All other bits read 0. The teardown-queue register (`cfg_sel`=1) keeps bits 11:0.
- R3: A configuration write with bit 30 set while bit 31 currently reads 1 starts a teardown. From the next cycle `busy` is 1 and `pop_req` is asserted with `pop_qnum` equal to the teardown-queue register.
- R4: A configuration write with bit 30 set while the channel is disabled (bit 31 reads 0) starts nothing. `busy` stays 0, no pop request appears, and bit 30 reads back 0.
- R5: A pop answer with `pop_desc` equal to 0 means the free queue is empty. The block keeps `pop_req` asserted and retries on every cycle until a non-zero descriptor arrives.
- R6: After a non-zero pop answer, the block requests a record write with `rec_wr_addr` equal to the popped descriptor. `rec_wr_data` has 0x13 in bits 31:27, bit 16 set to 1 only for a receive channel, `CHAN_ID` in bits 4:0, and all other bits 0.
- R7: After the record write is acknowledged, the block asserts `push_req` with `push_desc` equal to the popped descriptor and `push_qnum` equal to the completion queue field of the configuration word.
- R8: While `busy` is 1, bits 31 and 30 of the configuration word read 1. On the cycle after the push is acknowledged, `busy` is 0 and bits 31 and 30 read 0, while the other fields keep their values.
- R9: Register writes of either register made while `busy` is 1 have no effect.
- R10: Writing 0 to the configuration word after a teardown makes the whole word read 0.
- R11: At most one of `pop_req`, `rec_wr_req` and `push_req` is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 configuration word, 1 teardown-queue number |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| busy | output | 1 | Teardown sequence in progress |
| pop_req | output | 1 | Request a descriptor from the teardown free queue |
| pop_qnum | output | 12 | Queue to pop from |
| pop_ack | input | 1 | Pop answer valid |
| pop_desc | input | 32 | Popped descriptor address, 0 when the queue is empty |
| rec_wr_req | output | 1 | Request to write the teardown record |
| rec_wr_addr | output | 32 | Descriptor address the record is written to |
| rec_wr_data | output | 32 | Teardown record word |
| rec_wr_ack | input | 1 | Record write accepted |
| push_req | output | 1 | Request to push the descriptor to the completion queue |
| push_qnum | output | 12 | Completion queue number |
| push_desc | output | 32 | Descriptor being pushed |
| push_ack | input | 1 | Push accepted |

## Verification
On every cycle, the assertions check the following:
- the three handshake requests are mutually exclusive;
- an empty pop answer keeps the pop request alive;
- a good pop is followed by a record write to that same address, with the right type code;
- the enable and teardown bits read as set for the whole sequence;
- an accepted push returns the block to idle;
- a request to a disabled channel never starts a sequence.

Only the directed scenarios can show the rest:
- the exact record contents for receive and transmit channels;
- the queue numbers on the pop and push sides;
- the retry count against a queue that is empty for several cycles;
- register writes during a sequence being discarded;
- which configuration fields survive the end of a teardown.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    localparam int WORD_W     = 32;
    localparam int QNUM_W     = 12;
    localparam int DESC_W     = 32;
    localparam int PORT_W     = 5;

    localparam int BIT_EN     = 31;
    localparam int BIT_TD     = 30;
    localparam int BIT_RETRY  = 24;
    localparam int BIT_HOST   = 14;

    localparam logic [4:0] REC_TYPE = 5'h13;
    localparam int REC_TYPE_LSB = 27;
    localparam int REC_RX_BIT   = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_POP   = 2'd1,
        ST_WRITE = 2'd2,
        ST_PUSH  = 2'd3
    } tdc_state_e;

    typedef struct packed {
        logic              en;
        logic              td;
        logic              retry;
        logic              host;
        logic [QNUM_W-1:0] cq;
    } chan_cfg_t;

    function automatic logic [WORD_W-1:0] pack_cfg(input chan_cfg_t c);
        logic [WORD_W-1:0] w;
        w              = '0;
        w[BIT_EN]      = c.en;
        w[BIT_TD]      = c.td;
        w[BIT_RETRY]   = c.retry;
        w[BIT_HOST]    = c.host;
        w[QNUM_W-1:0]  = c.cq;
        return w;
    endfunction

    function automatic chan_cfg_t unpack_cfg(input logic [WORD_W-1:0] w,
                                             input logic is_rx);
        chan_cfg_t c;
        c.en    = w[BIT_EN];
        c.td    = w[BIT_TD];
        c.retry = is_rx & w[BIT_RETRY];
        c.host  = is_rx & w[BIT_HOST];
        c.cq    = w[QNUM_W-1:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] make_record(input logic [PORT_W-1:0] port,
                                                      input logic is_rx);
        logic [WORD_W-1:0] w;
        w                                = '0;
        w[REC_TYPE_LSB +: 5]             = REC_TYPE;
        w[REC_RX_BIT]                    = is_rx;
        w[PORT_W-1:0]                    = port;
        return w;
    endfunction

endpackage

// File: rtl/tdc_cfg_reg.sv
module tdc_cfg_reg
    import tdc_pkg::*;
#(
    parameter bit IS_RX = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              sel,
    input  logic [WORD_W-1:0] wdata,
    input  logic              busy,
    input  logic              td_done,
    output chan_cfg_t         cfg,
    output logic [QNUM_W-1:0] tdq,
    output logic              td_start,
    output logic [WORD_W-1:0] rdata
);

    chan_cfg_t cfg_q;
    chan_cfg_t cfg_next;
    logic [QNUM_W-1:0] tdq_q;

    // A teardown only starts on an enabled, idle channel
    assign td_start = we && !sel && wdata[BIT_TD] && cfg_q.en && !busy;

    always_comb begin
        cfg_next = unpack_cfg(wdata, IS_RX);
        if (td_start) begin
            cfg_next.en = 1'b1;
            cfg_next.td = 1'b1;
        end else begin
            cfg_next.td = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            tdq_q <= '0;
        end else if (td_done) begin
            cfg_q.en <= 1'b0;
            cfg_q.td <= 1'b0;
        end else if (we && !busy) begin
            if (!sel) begin
                cfg_q <= cfg_next;
            end else begin
                tdq_q <= wdata[QNUM_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (!sel) begin
            rdata = pack_cfg(cfg_q);
        end else begin
            rdata[QNUM_W-1:0] = tdq_q;
        end
    end

    assign cfg = cfg_q;
    assign tdq = tdq_q;

endmodule

// File: rtl/tdc_record.sv
module tdc_record
    import tdc_pkg::*;
#(
    parameter int unsigned CHAN_ID = 0,
    parameter bit          IS_RX   = 1'b1
) (
    output logic [WORD_W-1:0] rec
);

    logic rx_flag;

    generate
        if (IS_RX) begin : g_rx
            assign rx_flag = 1'b1;
        end else begin : g_tx
            assign rx_flag = 1'b0;
        end
    endgenerate

    localparam logic [PORT_W-1:0] PORT = CHAN_ID[PORT_W-1:0];

    assign rec = make_record(PORT, rx_flag);

endmodule

// File: rtl/tdc_seq.sv
module tdc_seq
    import tdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              td_start,
    input  logic [QNUM_W-1:0] tdq,
    input  logic [QNUM_W-1:0] cq,
    input  logic              pop_ack,
    input  logic [DESC_W-1:0] pop_desc,
    input  logic              wr_ack,
    input  logic              push_ack,
    output logic              pop_req,
    output logic [QNUM_W-1:0] pop_qnum,
    output logic              wr_req,
    output logic [DESC_W-1:0] wr_addr,
    output logic              push_req,
    output logic [QNUM_W-1:0] push_qnum,
    output logic [DESC_W-1:0] push_desc,
    output logic              busy,
    output logic              td_done
);

    tdc_state_e        state;
    logic [DESC_W-1:0] desc_q;
    logic              got_desc;

    assign got_desc = pop_ack && (pop_desc != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            desc_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE:  if (td_start) state <= ST_POP;
                ST_POP: begin
                    // an empty answer leaves the request up for another try
                    if (got_desc) begin
                        desc_q <= pop_desc;
                        state  <= ST_WRITE;
                    end
                end
                ST_WRITE: if (wr_ack)   state <= ST_PUSH;
                ST_PUSH:  if (push_ack) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign pop_req   = (state == ST_POP);
    assign pop_qnum  = tdq;
    assign wr_req    = (state == ST_WRITE);
    assign wr_addr   = desc_q;
    assign push_req  = (state == ST_PUSH);
    assign push_qnum = cq;
    assign push_desc = desc_q;
    assign busy      = (state != ST_IDLE);
    assign td_done   = push_req && push_ack;

endmodule

// File: rtl/dma_td_ctrl.sv
module dma_td_ctrl
    import tdc_pkg::*;
#(
    parameter int unsigned CHAN_ID = 3,
    parameter bit          IS_RX   = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    output logic              busy,
    output logic              pop_req,
    output logic [QNUM_W-1:0] pop_qnum,
    input  logic              pop_ack,
    input  logic [DESC_W-1:0] pop_desc,
    output logic              rec_wr_req,
    output logic [DESC_W-1:0] rec_wr_addr,
    output logic [WORD_W-1:0] rec_wr_data,
    input  logic              rec_wr_ack,
    output logic              push_req,
    output logic [QNUM_W-1:0] push_qnum,
    output logic [DESC_W-1:0] push_desc,
    input  logic              push_ack
);

    chan_cfg_t         cfg;
    logic [QNUM_W-1:0] tdq;
    logic              td_start;
    logic              td_done;

    tdc_cfg_reg #(.IS_RX(IS_RX)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata),
        .busy     (busy),
        .td_done  (td_done),
        .cfg      (cfg),
        .tdq      (tdq),
        .td_start (td_start),
        .rdata    (cfg_rdata)
    );

    tdc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .td_start  (td_start),
        .tdq       (tdq),
        .cq        (cfg.cq),
        .pop_ack   (pop_ack),
        .pop_desc  (pop_desc),
        .wr_ack    (rec_wr_ack),
        .push_ack  (push_ack),
        .pop_req   (pop_req),
        .pop_qnum  (pop_qnum),
        .wr_req    (rec_wr_req),
        .wr_addr   (rec_wr_addr),
        .push_req  (push_req),
        .push_qnum (push_qnum),
        .push_desc (push_desc),
        .busy      (busy),
        .td_done   (td_done)
    );

    tdc_record #(.CHAN_ID(CHAN_ID), .IS_RX(IS_RX)) u_rec (
        .rec (rec_wr_data)
    );

endmodule

// File: rtl/dma_td_ctrl_chk.sv
module dma_td_ctrl_chk
    import tdc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic              cfg_sel,
    input logic [WORD_W-1:0] cfg_rdata,
    input logic              busy,
    input logic              pop_req,
    input logic              pop_ack,
    input logic [DESC_W-1:0] pop_desc,
    input logic              rec_wr_req,
    input logic [DESC_W-1:0] rec_wr_addr,
    input logic [WORD_W-1:0] rec_wr_data,
    input logic              push_req,
    input logic              push_ack
);

    p_one_req_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pop_req, rec_wr_req, push_req}));

    p_pop_retry_r5: assert property (@(posedge clk) disable iff (rst)
        (pop_req && (!pop_ack || pop_desc == '0)) |=> pop_req);

    p_wr_addr_r6: assert property (@(posedge clk) disable iff (rst)
        (pop_req && pop_ack && pop_desc != '0) |=>
            (rec_wr_req && rec_wr_addr == $past(pop_desc)));

    p_rec_type_r6: assert property (@(posedge clk) disable iff (rst)
        rec_wr_req |-> (rec_wr_data[31:27] == 5'h13));

    p_flags_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !cfg_sel) |-> (cfg_rdata[31:30] == 2'b11));

    p_idle_after_push_r8: assert property (@(posedge clk) disable iff (rst)
        (push_req && push_ack) |=> !busy);

    p_ignore_disabled_r4: assert property (@(posedge clk) disable iff (rst)
        (!busy && cfg_we && !cfg_sel && !cfg_rdata[31]) |=> !busy);

endmodule

bind dma_td_ctrl dma_td_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_sel     (cfg_sel),
    .cfg_rdata   (cfg_rdata),
    .busy        (busy),
    .pop_req     (pop_req),
    .pop_ack     (pop_ack),
    .pop_desc    (pop_desc),
    .rec_wr_req  (rec_wr_req),
    .rec_wr_addr (rec_wr_addr),
    .rec_wr_data (rec_wr_data),
    .push_req    (push_req),
    .push_ack    (push_ack)
);

// File: tb/dma_td_ctrl_bench.sv
module dma_td_ctrl_bench;

    localparam logic [31:0] EN    = 32'h8000_0000;
    localparam logic [31:0] TD    = 32'h4000_0000;
    localparam logic [31:0] RETRY = 32'h0100_0000;
    localparam logic [31:0] HOST  = 32'h0000_4000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // receive instance signals
    logic        we = 0, sel = 0;
    logic [31:0] wdata = 0, rdata;
    logic        busy, pop_req, pop_ack = 0, wr_req, wr_ack = 0, push_req, push_ack = 0;
    logic [11:0] pop_qnum, push_qnum;
    logic [31:0] pop_desc = 0, wr_addr, wr_data, push_desc;

    // transmit instance signals
    logic        t_we = 0, t_sel = 0;
    logic [31:0] t_wdata = 0, t_rdata;
    logic        t_busy, t_pop_req, t_pop_ack = 0, t_wr_req, t_wr_ack = 0, t_push_req, t_push_ack = 0;
    logic [11:0] t_pop_qnum, t_push_qnum;
    logic [31:0] t_pop_desc = 0, t_wr_addr, t_wr_data, t_push_desc;

    dma_td_ctrl #(.CHAN_ID(3), .IS_RX(1'b1)) u_dma_td_ctrl (
        .clk(clk), .rst(rst), .cfg_we(we), .cfg_sel(sel), .cfg_wdata(wdata),
        .cfg_rdata(rdata), .busy(busy), .pop_req(pop_req), .pop_qnum(pop_qnum),
        .pop_ack(pop_ack), .pop_desc(pop_desc), .rec_wr_req(wr_req),
        .rec_wr_addr(wr_addr), .rec_wr_data(wr_data), .rec_wr_ack(wr_ack),
        .push_req(push_req), .push_qnum(push_qnum), .push_desc(push_desc),
        .push_ack(push_ack)
    );

    dma_td_ctrl #(.CHAN_ID(7), .IS_RX(1'b0)) u_dma_td_ctrl_tx (
        .clk(clk), .rst(rst), .cfg_we(t_we), .cfg_sel(t_sel), .cfg_wdata(t_wdata),
        .cfg_rdata(t_rdata), .busy(t_busy), .pop_req(t_pop_req), .pop_qnum(t_pop_qnum),
        .pop_ack(t_pop_ack), .pop_desc(t_pop_desc), .rec_wr_req(t_wr_req),
        .rec_wr_addr(t_wr_addr), .rec_wr_data(t_wr_data), .rec_wr_ack(t_wr_ack),
        .push_req(t_push_req), .push_qnum(t_push_qnum), .push_desc(t_push_desc),
        .push_ack(t_push_ack)
    );

    // queue manager / memory model knobs and capture
    logic [31:0] free_desc = 32'h0000_1240;
    int          empty_left = 0, wr_wait = 0;
    int          pop_seen = 0, wr_seen = 0, push_seen = 0;
    logic [11:0] cap_pop_q, cap_push_q;
    logic [31:0] cap_wr_addr, cap_wr_data, cap_push_desc;
    int          t_wr_seen = 0;
    logic [31:0] t_cap_wr_data;
    logic [11:0] t_cap_pop_q, t_cap_push_q;

    initial begin
        forever begin
            @(negedge clk);
            pop_ack = pop_req;
            if (pop_req) begin
                pop_seen++;
                cap_pop_q = pop_qnum;
                if (empty_left > 0) begin
                    pop_desc = '0;
                    empty_left--;
                end else begin
                    pop_desc = free_desc;
                end
            end
            if (wr_req) begin
                if (wr_wait > 0) begin
                    wr_wait--;
                    wr_ack = 1'b0;
                end else begin
                    wr_ack = 1'b1;
                    wr_seen++;
                    cap_wr_addr = wr_addr;
                    cap_wr_data = wr_data;
                end
            end else begin
                wr_ack = 1'b0;
            end
            push_ack = push_req;
            if (push_req) begin
                push_seen++;
                cap_push_q    = push_qnum;
                cap_push_desc = push_desc;
            end
            t_pop_ack  = t_pop_req;
            t_pop_desc = 32'h0000_2000;
            if (t_pop_req) t_cap_pop_q = t_pop_qnum;
            t_wr_ack = t_wr_req;
            if (t_wr_req) begin
                t_wr_seen++;
                t_cap_wr_data = t_wr_data;
            end
            t_push_ack = t_push_req;
            if (t_push_req) t_cap_push_q = t_push_qnum;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic s, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; sel = s; wdata = d;
        @(negedge clk);
        we = 1'b0; sel = 1'b0;
        #1;
    endtask

    task automatic rd_cfg(input logic s, output logic [31:0] v);
        @(negedge clk);
        sel = s;
        #1;
        v = rdata;
        sel = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200; i++) begin
            if (!busy) break;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic t_wr_cfg(input logic [31:0] d);
        @(negedge clk);
        t_we = 1'b1; t_wdata = d;
        @(negedge clk);
        t_we = 1'b0;
        #1;
    endtask

    task automatic test_reset();
        logic [31:0] v;
        rd_cfg(1'b0, v); check("R1 cfg word", v, 32'h0);
        rd_cfg(1'b1, v); check("R1 tdq reg", v, 32'h0);
        check("R1 busy/reqs", {28'h0, busy, pop_req, wr_req, push_req}, 32'h0);
    endtask

    task automatic test_readback();
        logic [31:0] v;
        wr_cfg(1'b0, 32'hFFFF_FFFF & ~TD);
        rd_cfg(1'b0, v); check("R2 rx readback", v, EN | RETRY | HOST | 32'hFFF);
        wr_cfg(1'b1, 32'hABCD_E01F);
        rd_cfg(1'b1, v); check("R2 tdq readback", v, 32'h0000_001F);
        t_wr_cfg(EN | RETRY | HOST | 32'h07D);
        @(negedge clk); #1;
        check("R2 tx masks retry/host", t_rdata, EN | 32'h07D);
    endtask

    task automatic test_basic_teardown();
        logic [31:0] v;
        wr_cfg(1'b0, EN | RETRY | HOST | 32'h06D);
        pop_seen = 0; wr_seen = 0; push_seen = 0; empty_left = 0;
        free_desc = 32'h0000_1240;
        wr_cfg(1'b0, EN | TD | RETRY | HOST | 32'h06D);
        check("R3 busy after start", {31'h0, busy}, 32'h1);
        check("R3 pop qnum", {20'h0, pop_qnum}, 32'h01F);
        wait_idle();
        check("R6 record addr", cap_wr_addr, 32'h0000_1240);
        check("R6 rx record word", cap_wr_data, 32'h9801_0003);
        check("R7 push qnum", {20'h0, cap_push_q}, 32'h06D);
        check("R7 push desc", cap_push_desc, 32'h0000_1240);
        check("R11 one of each handshake", pop_seen * 100 + wr_seen * 10 + push_seen, 111);
        rd_cfg(1'b0, v);
        check("R8 fields kept, en/td cleared", v, RETRY | HOST | 32'h06D);
        check("R8 busy low at end", {31'h0, busy}, 32'h0);
        wr_cfg(1'b0, 32'h0);
        rd_cfg(1'b0, v); check("R10 zero write", v, 32'h0);
    endtask

    task automatic test_disabled_ignored();
        logic [31:0] v;
        pop_seen = 0;
        wr_cfg(1'b0, 32'h0);
        wr_cfg(1'b0, TD | 32'h011);
        repeat (4) @(negedge clk);
        #1;
        check("R4 busy stays low", {31'h0, busy}, 32'h0);
        check("R4 no pop", pop_seen, 0);
        rd_cfg(1'b0, v); check("R4 td bit reads 0", v, 32'h011);
    endtask

    task automatic test_empty_retry();
        wr_cfg(1'b0, EN | 32'h022);
        pop_seen = 0; push_seen = 0; empty_left = 4;
        free_desc = 32'h0000_3380;
        wr_cfg(1'b0, EN | TD | 32'h022);
        repeat (3) @(negedge clk);
        #1;
        check("R5 busy while queue empty", {31'h0, busy}, 32'h1);
        check("R5 still popping", {31'h0, pop_req}, 32'h1);
        wait_idle();
        check("R5 pop attempts", pop_seen, 5);
        check("R5 pushed desc", cap_push_desc, 32'h0000_3380);
    endtask

    task automatic test_busy_writes();
        logic [31:0] v;
        wr_cfg(1'b0, EN | HOST | 32'h044);
        wr_cfg(1'b1, 32'h01F);
        wr_wait = 12;
        wr_cfg(1'b0, EN | TD | HOST | 32'h044);
        rd_cfg(1'b0, v);
        check("R8 en/td read 1 while busy", {30'h0, v[31:30]}, 32'h3);
        wr_cfg(1'b0, 32'h0);
        wr_cfg(1'b1, 32'h009);
        check("R9 still busy", {31'h0, busy}, 32'h1);
        wait_idle();
        rd_cfg(1'b0, v); check("R9 cfg write ignored", v, HOST | 32'h044);
        rd_cfg(1'b1, v); check("R9 tdq write ignored", v, 32'h01F);
        check("R7 push qnum kept", {20'h0, cap_push_q}, 32'h044);
    endtask

    task automatic test_tx_teardown();
        t_wr_cfg(EN | TD | 32'h07D);
        for (int i = 0; i < 50; i++) begin
            if (!t_busy) break;
            @(negedge clk);
            #1;
        end
        check("R6 tx record word", t_cap_wr_data, 32'h9800_0007);
        check("R7 tx push qnum", {20'h0, t_cap_push_q}, 32'h07D);
        check("R3 tx pop qnum", {20'h0, t_cap_pop_q}, 32'h0);
        check("R8 tx cleared", t_rdata, 32'h07D);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R3 actual hung expected idle");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_readback();
        test_basic_teardown();
        test_disabled_ignored();
        test_empty_retry();
        test_busy_writes();
        test_tx_teardown();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule